// File: doc/BRIEF.md
# Output Frame Slip and Repeat Detector

This block sits beside a one-frame sample buffer. The incoming audio stream writes that buffer once per frame. A serial output port reads it, and in slave mode that port is timed by an external left/right clock that need not match the input frame rate. When the two rates drift apart, the output either reads the same input frame twice (a slip) or an input frame is overwritten before the output has taken it (a repeat). The block works on the internal 256Fs clock. After each frame-start preamble it looks back over the frame that has just ended and classifies what happened in it.

Each preamble closes one look-back window and opens the next. A fixed number of cycles after the preamble, the block reaches a verdict on the closed window. A window with no buffer update is a slip. In a slip, the output path is told to reuse the previous frame's data until the next verdict. A window with two buffer updates and no qualifying left/right clock edge between them is a repeat. A qualifying edge is the rising edge, or the falling edge when the polarity input is high. Either event raises a one-cycle pulse of its own type and sets a sticky flag. A status read clears the flag. The first preamble after reset only opens a window.

Top module: `frame_slip_monitor`

## Requirements
- R1: After reset, `slip_evt_flag`, `reuse_prev`, `slip_pulse` and `repeat_pulse` are all 0.
- R2: A verdict pulse goes high in the cycle that follows the 4th rising clock edge after the clock edge that samples `frame_stb` high (EVAL_DELAY = 4). The pulse is high for exactly one cycle.
- R3: If a closed window contains no `buf_upd` strobe, `slip_pulse` fires and `repeat_pulse` stays low.
- R4: If a closed window contains two `buf_upd` strobes with no qualifying edge between them, `repeat_pulse` fires and `slip_pulse` stays low.
- R5: If a closed window contains exactly one `buf_upd` strobe, neither pulse fires and `slip_evt_flag` keeps its previous value.
- R6: With `lr_pol` = 0 only a rising edge of `lrck` qualifies. With `lr_pol` = 1 only a falling edge qualifies.
- R7: `slip_evt_flag` goes to 1 in the cycle after either pulse. It stays at 1 until a `stat_rd` strobe with no pulse in the same cycle clears it.
- R8: A `stat_rd` strobe in the same cycle as a verdict pulse leaves `slip_evt_flag` at 1.
- R9: `reuse_prev` goes high with a slip verdict and stays high until the next verdict that is not a slip.
- R10: The first `frame_stb` after reset produces no verdict.
- R11: Two `buf_upd` strobes with a qualifying edge between them produce no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 256Fs internal clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_stb | input | 1 | One-cycle strobe at each frame-start preamble |
| buf_upd | input | 1 | One-cycle strobe when the sample buffer is written |
| lrck | input | 1 | Output left/right clock, asynchronous to clk |
| lr_pol | input | 1 | 0: rising lrck edge qualifies, 1: falling edge qualifies |
| stat_rd | input | 1 | Status read strobe; clears the sticky flag |
| slip_evt_flag | output | 1 | Sticky slip-or-repeat flag |
| reuse_prev | output | 1 | Tells the output path to send the previous frame again |
| slip_pulse | output | 1 | One-cycle slip verdict |
| repeat_pulse | output | 1 | One-cycle repeat verdict |

## Verification
Windows are built with zero, one and two buffer updates. Two-update windows are run with no lrck edge between the updates, with a rising edge between them and with a falling edge between them, under both polarity settings. This separates slip from repeat from a normal frame and shows that only the selected edge clears a repeat. The slip window is also used to measure the verdict latency, to show that `reuse_prev` holds and later drops, and to place a status read on the pulse cycle. A window that is open at reset is checked to show that it never gives a verdict.

// File: rtl/slip_mon_pkg.sv
package slip_mon_pkg;
   typedef enum logic [1:0] {
      VERD_NONE   = 2'd0,
      VERD_SLIP   = 2'd1,
      VERD_REPEAT = 2'd2
   } verdict_t;

   function automatic verdict_t classify(input logic had_update, input logic had_double);
      if (!had_update)     return VERD_SLIP;
      else if (had_double) return VERD_REPEAT;
      else                 return VERD_NONE;
   endfunction
endpackage

// File: rtl/lrclk_edge_qual.sv
module lrclk_edge_qual #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic lrck,
   input  logic lr_pol,
   output logic qual_edge
);
   logic [SYNC_STAGES-1:0] sync_q;
   logic                   last_q;

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q <= '0;
         last_q <= 1'b0;
      end else begin
         sync_q <= {sync_q[SYNC_STAGES-2:0], lrck};
         last_q <= sync_q[SYNC_STAGES-1];
      end
   end

   // R6: the polarity input picks which transition counts
   always_comb begin
      if (lr_pol) qual_edge = last_q & ~sync_q[SYNC_STAGES-1];
      else        qual_edge = ~last_q & sync_q[SYNC_STAGES-1];
   end
endmodule

// File: rtl/frame_window_track.sv
module frame_window_track (
   input  logic clk,
   input  logic rst_n,
   input  logic frame_stb,
   input  logic buf_upd,
   input  logic qual_edge,
   output logic snap_upd,
   output logic snap_double
);
   logic upd_any_q;
   logic edge_since_q;
   logic double_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         upd_any_q    <= 1'b0;
         edge_since_q <= 1'b0;
         double_q     <= 1'b0;
         snap_upd     <= 1'b0;
         snap_double  <= 1'b0;
      end else if (frame_stb) begin
         snap_upd     <= upd_any_q;
         snap_double  <= double_q;
         upd_any_q    <= buf_upd;
         edge_since_q <= qual_edge & ~buf_upd;
         double_q     <= 1'b0;
      end else if (buf_upd) begin
         if (upd_any_q && !edge_since_q && !qual_edge) double_q <= 1'b1;
         upd_any_q    <= 1'b1;
         edge_since_q <= 1'b0;
      end else if (qual_edge) begin
         edge_since_q <= 1'b1;
      end
   end

   // R4: a double update cannot be recorded inside a window that saw no update
   a_r4_double_needs_update: assert property (@(posedge clk) disable iff (!rst_n)
      double_q |-> upd_any_q);
endmodule

// File: rtl/slip_verdict_unit.sv
module slip_verdict_unit
   import slip_mon_pkg::*;
#(
   parameter int EVAL_DELAY = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic frame_stb,
   input  logic snap_upd,
   input  logic snap_double,
   output logic slip_pulse,
   output logic repeat_pulse,
   output logic reuse_prev
);
   localparam int CNT_W = $clog2(EVAL_DELAY + 1);

   logic [CNT_W-1:0] dly_q;
   logic             primed_q;
   verdict_t         verd;

   generate
      if (EVAL_DELAY < 1) begin : g_bad_delay
         $error("EVAL_DELAY must be at least 1");
      end
   endgenerate

   assign verd = classify(snap_upd, snap_double);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dly_q        <= '0;
         primed_q     <= 1'b0;
         slip_pulse   <= 1'b0;
         repeat_pulse <= 1'b0;
         reuse_prev   <= 1'b0;
      end else begin
         slip_pulse   <= 1'b0;
         repeat_pulse <= 1'b0;
         if (frame_stb) begin
            primed_q <= 1'b1;
            // R10: the first preamble only opens a window
            if (primed_q) dly_q <= CNT_W'(EVAL_DELAY);
         end else if (dly_q != '0) begin
            dly_q <= dly_q - 1'b1;
            if (dly_q == CNT_W'(1)) begin
               slip_pulse   <= (verd == VERD_SLIP);
               repeat_pulse <= (verd == VERD_REPEAT);
               reuse_prev   <= (verd == VERD_SLIP);
            end
         end
      end
   end

   a_r3_pulses_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({slip_pulse, repeat_pulse}));
   a_r2_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      (slip_pulse || repeat_pulse) |=> !(slip_pulse || repeat_pulse));
   a_r9_reuse_holds: assert property (@(posedge clk) disable iff (!rst_n)
      slip_pulse |=> reuse_prev);
endmodule

// File: rtl/frame_slip_monitor.sv
module frame_slip_monitor #(
   parameter int EVAL_DELAY  = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic frame_stb,
   input  logic buf_upd,
   input  logic lrck,
   input  logic lr_pol,
   input  logic stat_rd,
   output logic slip_evt_flag,
   output logic reuse_prev,
   output logic slip_pulse,
   output logic repeat_pulse
);
   logic qual_edge;
   logic snap_upd;
   logic snap_double;
   logic any_evt;

   lrclk_edge_qual #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
      .clk(clk), .rst_n(rst_n), .lrck(lrck), .lr_pol(lr_pol), .qual_edge(qual_edge)
   );

   frame_window_track u_track (
      .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb), .buf_upd(buf_upd),
      .qual_edge(qual_edge), .snap_upd(snap_upd), .snap_double(snap_double)
   );

   slip_verdict_unit #(.EVAL_DELAY(EVAL_DELAY)) u_verd (
      .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb), .snap_upd(snap_upd),
      .snap_double(snap_double), .slip_pulse(slip_pulse),
      .repeat_pulse(repeat_pulse), .reuse_prev(reuse_prev)
   );

   assign any_evt = slip_pulse | repeat_pulse;

   // R7/R8: sticky flag, a new event outranks a read in the same cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       slip_evt_flag <= 1'b0;
      else if (any_evt) slip_evt_flag <= 1'b1;
      else if (stat_rd) slip_evt_flag <= 1'b0;
   end

   a_r7_flag_sets: assert property (@(posedge clk) disable iff (!rst_n)
      any_evt |=> slip_evt_flag);
   a_r7_rise_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(slip_evt_flag) |-> $past(any_evt));
   a_r7_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_rd && !any_evt) |=> !slip_evt_flag);
   a_r8_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_rd && any_evt) |=> slip_evt_flag);
endmodule

// File: tb/sim_frame_slip_monitor.sv
`timescale 1ns/1ps
module sim_frame_slip_monitor;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic frame_stb = 1'b0, buf_upd = 1'b0, lrck = 1'b0, lr_pol = 1'b0, stat_rd = 1'b0;
   logic slip_evt_flag, reuse_prev, slip_pulse, repeat_pulse;
   int checks = 0, failures = 0;
   int n_slip = 0, n_rep = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   frame_slip_monitor u0 (
      .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb), .buf_upd(buf_upd),
      .lrck(lrck), .lr_pol(lr_pol), .stat_rd(stat_rd), .slip_evt_flag(slip_evt_flag),
      .reuse_prev(reuse_prev), .slip_pulse(slip_pulse), .repeat_pulse(repeat_pulse)
   );

   always @(negedge clk) begin
      if (slip_pulse)   n_slip++;
      if (repeat_pulse) n_rep++;
   end

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic pre();
      frame_stb = 1'b1; tick(1); frame_stb = 1'b0;
   endtask

   task automatic upd();
      buf_upd = 1'b1; tick(1); buf_upd = 1'b0; tick(5);
   endtask

   task automatic set_lr(input logic v);
      lrck = v; tick(5);
   endtask

   task automatic rd();
      stat_rd = 1'b1; tick(1); stat_rd = 1'b0; tick(1);
   endtask

   task automatic close_window(output int s, output int r);
      n_slip = 0; n_rep = 0;
      pre(); tick(8);
      s = n_slip; r = n_rep;
   endtask

   task automatic t_reset();
      chk("R1", "flag", slip_evt_flag, 0);
      chk("R1", "reuse", reuse_prev, 0);
      chk("R1", "slip_pulse", slip_pulse, 0);
      chk("R1", "repeat_pulse", repeat_pulse, 0);
   endtask

   task automatic t_prime();
      int s, r;
      close_window(s, r);
      chk("R10", "slip on first preamble", s, 0);
      chk("R10", "repeat on first preamble", r, 0);
      chk("R10", "flag", slip_evt_flag, 0);
   endtask

   task automatic t_normal();
      int s, r;
      upd();
      close_window(s, r);
      chk("R5", "slips", s, 0);
      chk("R5", "repeats", r, 0);
      chk("R5", "flag", slip_evt_flag, 0);
   endtask

   task automatic t_slip();
      int lat = -1;
      n_slip = 0; n_rep = 0;
      pre();
      for (int k = 1; k <= 10; k++) begin
         tick(1);
         if (slip_pulse && lat < 0) lat = k;
      end
      chk("R2", "verdict latency", lat, 4);
      chk("R2", "pulse width", n_slip, 1);
      chk("R3", "repeat on slip", n_rep, 0);
      chk("R7", "flag after slip", slip_evt_flag, 1);
      chk("R9", "reuse after slip", reuse_prev, 1);
   endtask

   task automatic t_sticky();
      int s, r;
      upd();
      chk("R9", "reuse held before next verdict", reuse_prev, 1);
      close_window(s, r);
      chk("R5", "no event", s + r, 0);
      chk("R7", "flag stays set", slip_evt_flag, 1);
      chk("R9", "reuse dropped", reuse_prev, 0);
      rd();
      chk("R7", "flag cleared by read", slip_evt_flag, 0);
   endtask

   task automatic t_repeat();
      int s, r;
      lr_pol = 1'b0;
      upd(); upd();
      close_window(s, r);
      chk("R4", "repeats", r, 1);
      chk("R4", "slips", s, 0);
      chk("R4", "flag", slip_evt_flag, 1);
      chk("R9", "reuse on repeat", reuse_prev, 0);
      rd();
   endtask

   task automatic t_edge_between();
      int s, r;
      upd(); set_lr(1'b1); upd();
      close_window(s, r);
      chk("R11", "events with rising edge between", s + r, 0);
      chk("R11", "flag", slip_evt_flag, 0);
   endtask

   task automatic t_pol();
      int s, r;
      lr_pol = 1'b1;
      upd(); set_lr(1'b0); upd();
      close_window(s, r);
      chk("R6", "events with falling edge, pol=1", s + r, 0);
      upd(); set_lr(1'b1); upd();
      close_window(s, r);
      chk("R6", "repeat with rising edge, pol=1", r, 1);
      rd();
      lr_pol = 1'b0;
      upd(); set_lr(1'b0); upd();
      close_window(s, r);
      chk("R6", "repeat with falling edge, pol=0", r, 1);
      rd();
      chk("R7", "flag cleared", slip_evt_flag, 0);
   endtask

   task automatic t_event_wins();
      n_slip = 0;
      pre();
      tick(4);
      stat_rd = 1'b1; tick(1); stat_rd = 1'b0; tick(2);
      chk("R3", "slip seen", n_slip, 1);
      chk("R8", "flag after read on pulse cycle", slip_evt_flag, 1);
      rd();
      chk("R7", "later read clears", slip_evt_flag, 0);
   endtask

   initial begin
      tick(3);
      t_reset();
      rst_n = 1'b1;
      tick(2);
      t_reset();
      t_prime();
      t_normal();
      t_slip();
      t_sticky();
      t_repeat();
      t_edge_between();
      t_pol();
      t_event_wins();
      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++; failures++;
         $display("FAIL watchdog run did not finish actual=1 expected=0");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule